// File: doc/BRIEF.md
# Register-Mapped Serial Port with Byte Queues

This block is a serial transmitter and receiver for 8N1 character frames: one start bit, eight data bits sent least significant bit first, and one stop bit. A processor drives it through a simple word-addressed register bus. Each direction has an eight-entry byte queue. The bit rate is set by a programmable divisor, and each direction can be enabled on its own.

Status travels inside the data words, so software does not need a separate status register. Reading the transmit data word shows whether the transmit queue is full. Reading the receive data word returns a byte and a flag that says whether the byte is valid. A single interrupt output can follow two things: the fill level of the receive queue rising above a programmed level, and the fill level of the transmit queue falling below a programmed level.

The receiver detects a start edge and confirms the start bit at half a bit time. It then samples each later bit at its centre. A frame whose stop bit reads 0 is discarded.

Top module: `uart_mmio`

## Requirements
- R1: One bit on `txd` lasts exactly DIV+1 clock cycles, where DIV is the divisor register. Frames are one low start bit, data bits 0 to 7, and one high stop bit. `txd` rests high when idle.
- R2: A write to word 0 (transmit data) queues wdata[7:0] only when the transmit queue holds fewer than 8 bytes. Otherwise the write is dropped. Reading word 0 returns bit 31 = 1 when the queue is full, and all other bits 0.
- R3: Word 2 bit 0 enables transmission. While it is 0, no new frame starts and queued bytes are held. Once it is set, they are sent in write order.
- R4: Reading word 1 (receive data) returns the oldest received byte in bits 7:0, with bits 30:8 zero and bit 31 = 0, and removes that byte. When the receive queue is empty, the read returns bit 31 = 1 and removes nothing.
- R5: Word 3 bit 0 enables reception. A frame that arrives while it is 0 is not stored.
- R6: A start bit is accepted only if the line is still low half a bit time after the falling edge. A frame whose stop bit samples low is discarded.
- R7: A byte that completes while the receive queue holds 8 bytes is dropped, and the 8 stored bytes are kept in order.
- R8: `irq` is high while word 4 bit 1 is set and the receive count is greater than word 3 bits 18:16. It is also high while word 4 bit 0 is set and the transmit count is less than word 2 bits 18:16.
- R9: Word 5 bits 15:0 hold the divisor. All control words read back what was written and reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| irq | output | 1 | Queue-level interrupt |

## Verification
The main serial path is swept with all 256 byte values in a loopback from `txd` to `rxd`. This pattern separates errors in bit order, in the per-bit width and in data bits that are stuck. Frames are also driven onto `rxd` and decoded from `txd` at two different divisors, which shows that the bit time follows the divisor rather than a fixed count. Separate patterns cover the following:
- a one-cycle low glitch, which the start-bit check must reject;
- a frame with a low stop bit, which must be discarded;
- nine frames sent back to back, which must fill the queue and drop only the last;
- fill levels on both sides of each watermark, which must switch the interrupt at the right count.

// File: rtl/uart_mmio_pkg.sv
package uart_mmio_pkg;
  localparam int REG_TXDATA = 0;
  localparam int REG_RXDATA = 1;
  localparam int REG_TXCTRL = 2;
  localparam int REG_RXCTRL = 3;
  localparam int REG_IE     = 4;
  localparam int REG_DIV    = 5;
  localparam int FLAG_POS   = 31;
  localparam int WM_LSB     = 16;
  localparam int WM_W       = 3;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_ok, rd_ok;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign count = cnt_q;
  assign rdata = mem[rptr_q];
  assign wr_ok = push & ~full;
  assign rd_ok = pop & ~empty;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (wr_ok) wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (rd_ok) rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    case ({wr_ok, rd_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr_q] <= wdata;
  end

  // R2: occupancy never exceeds the depth
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R7: a push into a full queue without a pop leaves it full
  a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);
  // R4: a pop on an empty queue leaves it empty
  a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/uart_tx.sv
module uart_tx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  input  logic             q_empty,
  input  logic [7:0]       q_data,
  output logic             pop,
  output logic             txd
);
  localparam int FRAME_BITS = 10;
  localparam logic [3:0] LAST_BIT = 4'(FRAME_BITS - 1);

  logic                  busy_q, busy_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [3:0]            bit_q, bit_d;
  logic [DIV_W-1:0]      cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    bit_d  = bit_q;
    cnt_d  = cnt_q;
    pop    = 1'b0;
    if (!busy_q) begin
      if (en && !q_empty) begin
        pop    = 1'b1;
        busy_d = 1'b1;
        sh_d   = {1'b1, q_data, 1'b0};
        cnt_d  = div;
        bit_d  = '0;
      end
    end else if (cnt_q == '0) begin
      cnt_d = div;
      sh_d  = {1'b1, sh_q[FRAME_BITS-1:1]};
      if (bit_q == LAST_BIT) busy_d = 1'b0;
      else                   bit_d  = bit_q + 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      bit_q  <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      cnt_q  <= cnt_d;
    end
  end

  assign txd = busy_q ? sh_q[0] : 1'b1;

  // R1: the line rests high between frames
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> txd);
  // R1: every frame opens with a low start bit
  a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !txd);
  // R3: while disabled and idle, no frame starts
  a_r3_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !busy_q) |=> !busy_q);
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_mmio_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  input  logic             rxd,
  output logic             push,
  output logic [7:0]       data
);
  logic             meta_q, line_q;
  rx_state_e        st_q, st_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      line_q <= 1'b1;
    end else begin
      meta_q <= rxd;
      line_q <= meta_q;
    end
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    push  = 1'b0;
    case (st_q)
      RX_IDLE: begin
        if (!line_q) begin
          st_d  = RX_START;
          cnt_d = div >> 1;
        end
      end
      RX_START: begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else if (!line_q) begin
          st_d  = RX_DATA;
          cnt_d = div;
          bit_d = '0;
        end else st_d = RX_IDLE;
      end
      RX_DATA: begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else begin
          sh_d  = {line_q, sh_q[7:1]};
          cnt_d = div;
          if (bit_q == 3'd7) st_d = RX_STOP;
          else               bit_d = bit_q + 1'b1;
        end
      end
      default: begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else begin
          push = line_q;
          st_d = RX_IDLE;
        end
      end
    endcase
    if (!en) begin
      st_d = RX_IDLE;
      push = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
    end
  end

  assign data = sh_q;

  // R6: a byte is only delivered at the end of the stop-bit phase
  a_r6_push_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (st_q == RX_STOP));
  // R5: a disabled receiver stays idle
  a_r5_idle_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (st_q == RX_IDLE));
endmodule

// File: rtl/uart_mmio.sv
module uart_mmio
  import uart_mmio_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DIV_W  = 16,
  parameter int DEPTH  = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rxd,
  output logic              txd,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_TXD = ADDR_W'(REG_TXDATA);
  localparam logic [ADDR_W-1:0] A_RXD = ADDR_W'(REG_RXDATA);
  localparam logic [ADDR_W-1:0] A_TXC = ADDR_W'(REG_TXCTRL);
  localparam logic [ADDR_W-1:0] A_RXC = ADDR_W'(REG_RXCTRL);
  localparam logic [ADDR_W-1:0] A_IE  = ADDR_W'(REG_IE);
  localparam logic [ADDR_W-1:0] A_DIV = ADDR_W'(REG_DIV);

  logic rst_meta_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  logic            tx_en_q, rx_en_q, ie_tx_q, ie_rx_q;
  logic [WM_W-1:0] tx_wm_q, rx_wm_q;
  logic [DIV_W-1:0] div_q;

  logic wr, rd, wr_txc, wr_rxc, wr_ie, wr_div, tx_push, rx_pop;
  assign wr      = bus_sel & bus_we;
  assign rd      = bus_sel & ~bus_we;
  assign wr_txc  = wr & (bus_addr == A_TXC);
  assign wr_rxc  = wr & (bus_addr == A_RXC);
  assign wr_ie   = wr & (bus_addr == A_IE);
  assign wr_div  = wr & (bus_addr == A_DIV);
  assign tx_push = wr & (bus_addr == A_TXD);
  assign rx_pop  = rd & (bus_addr == A_RXD);

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      tx_en_q <= 1'b0;
      tx_wm_q <= '0;
      rx_en_q <= 1'b0;
      rx_wm_q <= '0;
      ie_tx_q <= 1'b0;
      ie_rx_q <= 1'b0;
      div_q   <= '0;
    end else begin
      if (wr_txc) begin
        tx_en_q <= bus_wdata[0];
        tx_wm_q <= bus_wdata[WM_LSB +: WM_W];
      end
      if (wr_rxc) begin
        rx_en_q <= bus_wdata[0];
        rx_wm_q <= bus_wdata[WM_LSB +: WM_W];
      end
      if (wr_ie) begin
        ie_tx_q <= bus_wdata[0];
        ie_rx_q <= bus_wdata[1];
      end
      if (wr_div) div_q <= bus_wdata[DIV_W-1:0];
    end
  end

  logic [7:0]    txq_data, rxq_data, rx_byte;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, rx_full, rx_empty, tx_pop, rx_push;

  uart_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_q), .push(tx_push), .wdata(bus_wdata[7:0]),
    .pop(tx_pop), .rdata(txq_data), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  uart_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_q), .push(rx_push), .wdata(rx_byte),
    .pop(rx_pop), .rdata(rxq_data), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  uart_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_q), .en(tx_en_q), .div(div_q), .q_empty(tx_empty),
    .q_data(txq_data), .pop(tx_pop), .txd(txd)
  );

  uart_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_q), .en(rx_en_q), .div(div_q), .rxd(rxd),
    .push(rx_push), .data(rx_byte)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_TXD: bus_rdata[FLAG_POS] = tx_full;
      A_RXD: begin
        bus_rdata[FLAG_POS] = rx_empty;
        bus_rdata[7:0]      = rx_empty ? 8'h00 : rxq_data;
      end
      A_TXC: begin
        bus_rdata[0]               = tx_en_q;
        bus_rdata[WM_LSB +: WM_W]  = tx_wm_q;
      end
      A_RXC: begin
        bus_rdata[0]               = rx_en_q;
        bus_rdata[WM_LSB +: WM_W]  = rx_wm_q;
      end
      A_IE:  bus_rdata[1:0] = {ie_rx_q, ie_tx_q};
      A_DIV: bus_rdata[DIV_W-1:0] = div_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = (ie_rx_q & (rx_cnt > CW'(rx_wm_q))) |
               (ie_tx_q & (tx_cnt < CW'(tx_wm_q)));

  // R9: the divisor only changes on a write to its word
  a_r9_div_hold: assert property (@(posedge clk) disable iff (!rst_q)
    !wr_div |=> $stable(div_q));
  // R5: the receive queue never grows while reception is disabled
  a_r5_no_fill: assert property (@(posedge clk) disable iff (!rst_q)
    !rx_en_q |=> (rx_cnt <= $past(rx_cnt)));
  // R8: with both enables clear the interrupt stays low
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_q)
    (!ie_rx_q && !ie_tx_q) |-> !irq);
  // R7: a full receive queue keeps its count when a byte completes without a read
  a_r7_keep: assert property (@(posedge clk) disable iff (!rst_q)
    (rx_full && rx_push && !rx_pop) |=> (rx_cnt == CW'(DEPTH)));
endmodule

// File: tb/uart_mmio_test.sv
module uart_mmio_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk, rst_n, bus_sel, bus_we, txd, irq, drv_rx, loop;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  wire         rxd_w = loop ? txd : drv_rx;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done = 0;

  uart_mmio uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd(rxd_w), .txd(txd), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input logic stopv, input int per);
    logic [9:0] f;
    f = {stopv, b, 1'b0};
    for (int k = 0; k < 10; k++) begin
      drv_rx = f[k];
      repeat (per) @(negedge clk);
    end
    drv_rx = 1'b1;
  endtask

  task automatic cap(input int per, output logic [7:0] b, output logic ok);
    logic [9:0] f;
    int n;
    n = 0;
    ok = 1'b0;
    b = '0;
    while (txd !== 1'b0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (txd === 1'b0) begin
      for (int k = 0; k < 10; k++) begin
        repeat ((k == 0) ? per/2 : per) @(negedge clk);
        f[k] = txd;
      end
      b  = f[8:1];
      ok = (f[0] == 1'b0) && (f[9] == 1'b1);
    end
  endtask

  initial begin
    logic [31:0] d;
    logic [7:0]  b;
    logic        ok, hi;
    int          n;
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0; drv_rx = 1'b1; loop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    rd(3'd0, d); chk("R2 reset txdata", d, 32'h0);
    rd(3'd1, d); chk("R4 reset rxdata empty", d, 32'h8000_0000);
    rd(3'd5, d); chk("R9 reset div", d, 32'h0);
    chk("R8 reset irq", {31'b0, irq}, 32'h0);
    chk("R1 reset txd idle", {31'b0, txd}, 32'h1);

    // transmit queue, full flag, hold while disabled
    wr(3'd5, 32'd3);
    wr(3'd2, 32'h0004_0000);
    wr(3'd0 + 3'd4, 32'h1);
    rd(3'd2, d); chk("R9 txctrl readback", d, 32'h0004_0000);
    rd(3'd5, d); chk("R9 div readback", d, 32'd3);
    @(negedge clk); chk("R8 tx level below mark", {31'b0, irq}, 32'h1);
    for (int i = 0; i < 9; i++) wr(3'd0, 32'hA0 + i);
    rd(3'd0, d); chk("R2 full flag", d, 32'h8000_0000);
    chk("R8 tx level at mark", {31'b0, irq}, 32'h0);
    hi = 1'b1;
    repeat (60) begin @(negedge clk); if (txd !== 1'b1) hi = 1'b0; end
    chk("R3 no frame while disabled", {31'b0, hi}, 32'h1);
    wr(3'd2, 32'h0004_0001);
    for (int i = 0; i < 8; i++) begin
      cap(4, b, ok);
      chk("R1 frame shape", {31'b0, ok}, 32'h1);
      chk("R3 order / R2 data", {24'b0, b}, 32'hA0 + i);
    end
    hi = 1'b1;
    repeat (60) begin @(negedge clk); if (txd !== 1'b1) hi = 1'b0; end
    chk("R2 ninth byte dropped", {31'b0, hi}, 32'h1);
    rd(3'd0, d); chk("R2 not full", d, 32'h0);
    chk("R8 tx drained irq", {31'b0, irq}, 32'h1);

    // a second divisor
    wr(3'd5, 32'd6);
    wr(3'd0, 32'h5A);
    cap(7, b, ok);
    chk("R1 div6 frame", {31'b0, ok}, 32'h1);
    chk("R1 div6 data", {24'b0, b}, 32'h5A);
    wr(3'd5, 32'd3);
    wr(3'd4, 32'h0);
    repeat (20) @(negedge clk);

    // receive path, watermark, overflow
    wr(3'd3, 32'h0002_0001);
    wr(3'd4, 32'h2);
    send(8'h11, 1'b1, 4);
    send(8'h22, 1'b1, 4);
    repeat (6) @(negedge clk);
    chk("R8 rx count at mark", {31'b0, irq}, 32'h0);
    send(8'h33, 1'b1, 4);
    repeat (6) @(negedge clk);
    chk("R8 rx count above mark", {31'b0, irq}, 32'h1);
    for (int i = 4; i < 10; i++) send(8'(i * 8'h11), 1'b1, 4);
    repeat (6) @(negedge clk);
    for (int i = 1; i < 9; i++) begin
      rd(3'd1, d); chk("R4 R7 rx order", d, 32'(i * 8'h11));
    end
    rd(3'd1, d); chk("R7 ninth dropped, R4 empty", d, 32'h8000_0000);
    rd(3'd1, d); chk("R4 empty read pops nothing", d, 32'h8000_0000);
    chk("R8 irq after drain", {31'b0, irq}, 32'h0);

    // bad stop bit
    send(8'hC3, 1'b0, 4);
    repeat (40) @(negedge clk);
    rd(3'd1, d); chk("R6 bad stop discarded", d, 32'h8000_0000);

    // short glitch
    @(negedge clk); drv_rx = 1'b0;
    @(negedge clk); drv_rx = 1'b1;
    repeat (60) @(negedge clk);
    rd(3'd1, d); chk("R6 glitch rejected", d, 32'h8000_0000);

    // receiver disabled
    wr(3'd3, 32'h0);
    send(8'h5C, 1'b1, 4);
    repeat (10) @(negedge clk);
    wr(3'd3, 32'h1);
    rd(3'd1, d); chk("R5 disabled no store", d, 32'h8000_0000);

    // loopback sweep over every byte value
    wr(3'd2, 32'h1);
    loop = 1'b1;
    repeat (4) @(negedge clk);
    for (int v = 0; v < 256; v++) begin
      wr(3'd0, 32'(v));
      n = 0;
      d = 32'h8000_0000;
      while (d[31] && n < 200) begin
        rd(3'd1, d);
        n++;
      end
      chk("R1 R4 loopback byte", d, 32'(v));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule